// File: doc/BRIEF.md
# Fan Duty Ramp Limiter

This block moves the duty cycle of a cooling fan toward a requested value at a limited rate, so that audible speed changes stay gradual. The output duty changes by one least-significant step each time a programmable interval, counted in one-millisecond timebase ticks, has passed. It stops at the requested value and never passes it. Three rate contexts, one each for the local, first remote and second remote temperature channels, hold a 3-bit rate code and a divide-by-four slow flag. A 2-bit select input picks which context drives the output. A global stretch flag switches every context to a longer set of ramp times.

The rate code names the time of a full sweep from 0 to 255. The step interval is that time divided by 255, rounded to the nearest tick. A second policy applies when the surrounding controller reports that the temperature is under its lower threshold. The goal then becomes either zero or a programmed minimum duty, chosen by a mode flag. The goal is still approached at the limited rate, so the fan does not stop or restart abruptly. The rate fields, slow flags, stretch flag and select are captured in registers that clear on reset. The duty goal and the below-threshold inputs act directly.

Top module: `fan_duty_ramp`

## Requirements
- R1: While `rst` is high at a clock edge, `duty_o` becomes 0 and the captured rate fields, slow flags, stretch flag and select clear to 0. Ticks and the requested duty have no effect during reset.
- R2: With the stretch flag clear, rate codes 0 through 7 give step intervals of 147, 74, 49, 29, 18, 12, 6 and 3 ticks.
- R3: With the stretch flag set, rate codes 0 through 7 give step intervals of 205, 102, 68, 41, 25, 17, 9 and 4 ticks.
- R4: A context whose slow flag is set uses four times the interval from whichever table is active. The slow flag of a context that is not selected has no effect.
- R5: `chan_sel_i` value 0 selects the local context, 1 the first remote, 2 the second remote, and 3 the local context. Captured fields take effect one clock after they are presented.
- R6: Each time an interval elapses, `duty_o` moves one step toward the goal. It never passes the goal, and it holds at the goal while the goal is unchanged.
- R7: A change of the effective goal or of the selected interval restarts the tick count from zero and leaves `duty_o` unchanged.
- R8: While `below_limit_i` is 1 and `hold_min_i` is 0, the goal is 0 and is reached at the selected rate.
- R9: While `below_limit_i` is 1 and `hold_min_i` is 1, the goal is `min_duty_i`. When `below_limit_i` returns to 0, the goal is `target_duty_i` again, still at the limited rate.
- R10: `duty_o` changes only on a clock edge at which `tick_1ms_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1ms_i | input | 1 | One-cycle pulse per timebase millisecond |
| chan_sel_i | input | 2 | Selects the active rate context |
| rate_local_i | input | 3 | Rate code, local context |
| rate_rem1_i | input | 3 | Rate code, first remote context |
| rate_rem2_i | input | 3 | Rate code, second remote context |
| slow_local_i | input | 1 | Times-four slowdown, local context |
| slow_rem1_i | input | 1 | Times-four slowdown, first remote context |
| slow_rem2_i | input | 1 | Times-four slowdown, second remote context |
| extra_slow_i | input | 1 | Selects the stretched ramp-time table for all contexts |
| below_limit_i | input | 1 | Temperature is under its lower threshold |
| hold_min_i | input | 1 | Below threshold: 1 holds the minimum duty, 0 goes to zero |
| min_duty_i | input | 8 | Programmed minimum duty |
| target_duty_i | input | 8 | Requested duty |
| duty_o | output | 8 | Current rate-limited duty |

## Verification
The properties assume that `tick_1ms_i` is a single-cycle pulse and that all inputs are synchronous to `clk`. The minimum-duty hold property also assumes that `min_duty_i` stays steady while the block is below the threshold. The stimulus changes inputs only on falling clock edges. Each tick is a one-cycle pulse followed by an idle cycle. Goal and rate changes are made with ticks held low and are then left to settle for three cycles. The bench model can therefore treat every change as a clean restart of the count.

// File: rtl/fan_ramp_pkg.sv
package fan_ramp_pkg;

    localparam int unsigned DUTY_W      = 8;
    localparam int unsigned RATE_W      = 3;
    localparam int unsigned NUM_CH      = 3;
    localparam int unsigned SEL_W       = 2;
    localparam int unsigned SLOW_FACTOR = 4;
    localparam int unsigned FULL_SPAN   = (1 << DUTY_W) - 1;

    // Captured per-context rate setting
    typedef struct packed {
        logic [RATE_W-1:0] code;
        logic              slow;
    } chan_rate_t;

    // Policy applied while the temperature is under its lower threshold
    typedef enum logic {
        BELOW_OFF      = 1'b0,
        BELOW_HOLD_MIN = 1'b1
    } below_mode_e;

    // Full-scale sweep time in milliseconds for a rate code
    function automatic int unsigned sweep_ms(input logic [RATE_W-1:0] code,
                                             input logic              stretch);
        int unsigned ms;
        case ({stretch, code})
            4'b0_000: ms = 37500;
            4'b0_001: ms = 18800;
            4'b0_010: ms = 12500;
            4'b0_011: ms = 7500;
            4'b0_100: ms = 4700;
            4'b0_101: ms = 3100;
            4'b0_110: ms = 1600;
            4'b0_111: ms = 800;
            4'b1_000: ms = 52200;
            4'b1_001: ms = 26100;
            4'b1_010: ms = 17400;
            4'b1_011: ms = 10400;
            4'b1_100: ms = 6500;
            4'b1_101: ms = 4400;
            4'b1_110: ms = 2200;
            default:  ms = 1100;
        endcase
        return ms;
    endfunction

    // Ticks per one-LSB step: sweep time over span, rounded to nearest
    function automatic int unsigned step_interval(input logic [RATE_W-1:0] code,
                                                  input logic              stretch,
                                                  input logic              slow,
                                                  input int unsigned       span);
        int unsigned base;
        base = (2 * sweep_ms(code, stretch) + span) / (2 * span);
        return slow ? base * SLOW_FACTOR : base;
    endfunction

    localparam int unsigned MAX_INTV = step_interval('0, 1'b1, 1'b1, FULL_SPAN);
    localparam int unsigned INTV_W   = $clog2(MAX_INTV + 1);

endpackage

// File: rtl/fan_ramp_rate_sel.sv
module fan_ramp_rate_sel
    import fan_ramp_pkg::*;
#(
    parameter int unsigned CHANNELS = NUM_CH,
    parameter int unsigned SW       = SEL_W,
    parameter int unsigned SPAN     = FULL_SPAN,
    parameter int unsigned IW       = INTV_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CHANNELS*RATE_W-1:0] codes_i,
    input  logic [CHANNELS-1:0]        slow_i,
    input  logic                       stretch_i,
    input  logic [SW-1:0]              sel_i,
    output logic [IW-1:0]              interval_o
);

    logic          stretch_q;
    logic [SW-1:0] sel_q;
    logic [IW-1:0] ch_intv [CHANNELS];

    always_ff @(posedge clk) begin
        if (rst) begin
            stretch_q <= 1'b0;
            sel_q     <= '0;
        end else begin
            stretch_q <= stretch_i;
            sel_q     <= sel_i;
        end
    end

    for (genvar g = 0; g < CHANNELS; g++) begin : g_ctx
        chan_rate_t cfg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '0;
            end else begin
                cfg_q <= '{code: codes_i[g*RATE_W +: RATE_W], slow: slow_i[g]};
            end
        end

        assign ch_intv[g] = IW'(step_interval(cfg_q.code, stretch_q, cfg_q.slow, SPAN));

        // R4: a slowed context always steps on a multiple of four ticks
        a_r4_slow_multiple: assert property (@(posedge clk) disable iff (rst)
            cfg_q.slow |-> (ch_intv[g][1:0] == 2'b00));
    end

    // Out-of-range select values fall back to context 0 (local)
    always_comb begin
        interval_o = ch_intv[0];
        for (int i = 1; i < CHANNELS; i++) begin
            if (32'(sel_q) == i) begin
                interval_o = ch_intv[i];
            end
        end
    end

endmodule

// File: rtl/fan_ramp_policy.sv
module fan_ramp_policy
    import fan_ramp_pkg::*;
#(
    parameter int unsigned DW = DUTY_W
) (
    input  logic          below_i,
    input  logic          hold_min_i,
    input  logic [DW-1:0] min_duty_i,
    input  logic [DW-1:0] target_i,
    output logic [DW-1:0] goal_o
);

    below_mode_e mode;

    always_comb begin
        mode = below_mode_e'(hold_min_i);
        if (!below_i) begin
            goal_o = target_i;
        end else begin
            case (mode)
                BELOW_HOLD_MIN: goal_o = min_duty_i;
                default:        goal_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/fan_ramp_engine.sv
module fan_ramp_engine
    import fan_ramp_pkg::*;
#(
    parameter int unsigned DW = DUTY_W,
    parameter int unsigned IW = INTV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [DW-1:0] target_i,
    input  logic [IW-1:0] interval_i,
    output logic [DW-1:0] duty_o
);

    localparam logic [DW-1:0] ONE_LSB  = DW'(1);
    localparam logic [IW:0]   CNT_STEP = (IW+1)'(1);

    logic [DW-1:0] duty_q;
    logic [DW-1:0] goal_q;
    logic [IW-1:0] intv_q;
    logic [IW-1:0] cnt_q;
    logic [IW:0]   cnt_inc;
    logic          restart;
    logic          at_goal;
    logic          step_due;

    always_comb begin
        restart  = (target_i != goal_q) || (interval_i != intv_q);
        at_goal  = (duty_q == goal_q);
        cnt_inc  = {1'b0, cnt_q} + CNT_STEP;
        step_due = (cnt_inc >= {1'b0, intv_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            goal_q <= '0;
            intv_q <= '0;
            cnt_q  <= '0;
        end else if (restart) begin
            goal_q <= target_i;
            intv_q <= interval_i;
            cnt_q  <= '0;
        end else if (at_goal) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (step_due) begin
                cnt_q  <= '0;
                duty_q <= (goal_q > duty_q) ? duty_q + ONE_LSB : duty_q - ONE_LSB;
            end else begin
                cnt_q <= cnt_inc[IW-1:0];
            end
        end
    end

    assign duty_o = duty_q;

    // R1: reset forces the duty to zero
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (duty_q == '0));

    // R10: no movement without a timebase tick
    a_r10_tick_gates_step: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(duty_q));

    // R6: every change is exactly one LSB
    a_r6_one_lsb: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty_q) |-> ((duty_q == $past(duty_q) + ONE_LSB) ||
                              (duty_q == $past(duty_q) - ONE_LSB)));

    // R6: rising duty never passes the goal
    a_r6_no_overshoot_up: assert property (@(posedge clk) disable iff (rst)
        (duty_q < goal_q) |=> (duty_q <= $past(goal_q)));

    // R6: falling duty never passes the goal
    a_r6_no_overshoot_down: assert property (@(posedge clk) disable iff (rst)
        (duty_q > goal_q) |=> (duty_q >= $past(goal_q)));

    // R7: a restart clears the count and keeps the duty
    a_r7_restart_keeps_duty: assert property (@(posedge clk) disable iff (rst)
        restart |=> ((cnt_q == '0) && (duty_q == $past(duty_q))));

endmodule

// File: rtl/fan_duty_ramp.sv
module fan_duty_ramp
    import fan_ramp_pkg::*;
#(
    parameter int unsigned DW = DUTY_W,
    parameter int unsigned RW = RATE_W,
    parameter int unsigned SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_1ms_i,
    input  logic [SW-1:0] chan_sel_i,
    input  logic [RW-1:0] rate_local_i,
    input  logic [RW-1:0] rate_rem1_i,
    input  logic [RW-1:0] rate_rem2_i,
    input  logic          slow_local_i,
    input  logic          slow_rem1_i,
    input  logic          slow_rem2_i,
    input  logic          extra_slow_i,
    input  logic          below_limit_i,
    input  logic          hold_min_i,
    input  logic [DW-1:0] min_duty_i,
    input  logic [DW-1:0] target_duty_i,
    output logic [DW-1:0] duty_o
);

    localparam int unsigned CH   = NUM_CH;
    localparam int unsigned SPAN = (1 << DW) - 1;

    logic [CH*RW-1:0] codes;
    logic [CH-1:0]    slows;
    logic [INTV_W-1:0] interval;
    logic [DW-1:0]    goal;

    // Context index order: 0 local, 1 remote 1, 2 remote 2
    assign codes = {rate_rem2_i, rate_rem1_i, rate_local_i};
    assign slows = {slow_rem2_i, slow_rem1_i, slow_local_i};

    fan_ramp_rate_sel #(
        .CHANNELS (CH),
        .SW       (SW),
        .SPAN     (SPAN),
        .IW       (INTV_W)
    ) u_rate (
        .clk        (clk),
        .rst        (rst),
        .codes_i    (codes),
        .slow_i     (slows),
        .stretch_i  (extra_slow_i),
        .sel_i      (chan_sel_i),
        .interval_o (interval)
    );

    fan_ramp_policy #(
        .DW (DW)
    ) u_policy (
        .below_i    (below_limit_i),
        .hold_min_i (hold_min_i),
        .min_duty_i (min_duty_i),
        .target_i   (target_duty_i),
        .goal_o     (goal)
    );

    fan_ramp_engine #(
        .DW (DW),
        .IW (INTV_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_1ms_i),
        .target_i   (goal),
        .interval_i (interval),
        .duty_o     (duty_o)
    );

    // R8: once settled at zero under the off policy, the duty stays at zero
    a_r8_off_stays_zero: assert property (@(posedge clk) disable iff (rst)
        (below_limit_i && !hold_min_i && $past(below_limit_i && !hold_min_i) &&
         (duty_o == '0)) |=> (duty_o == '0));

    // R9: once at the minimum under the hold policy, the duty stays there
    a_r9_hold_min_stays: assert property (@(posedge clk) disable iff (rst)
        (below_limit_i && hold_min_i && $past(below_limit_i && hold_min_i) &&
         $stable(min_duty_i) && (duty_o == min_duty_i)) |=> (duty_o == $past(min_duty_i)));

endmodule

// File: tb/test_fan_duty_ramp.sv
module test_fan_duty_ramp;

    typedef struct {
        logic [7:0] duty;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] chan_sel = 2'd0;
    logic [2:0] rate_local = 3'd0;
    logic [2:0] rate_rem1 = 3'd0;
    logic [2:0] rate_rem2 = 3'd0;
    logic       slow_local = 1'b0;
    logic       slow_rem1 = 1'b0;
    logic       slow_rem2 = 1'b0;
    logic       extra_slow = 1'b0;
    logic       below = 1'b0;
    logic       hold_min = 1'b0;
    logic [7:0] min_duty = 8'd0;
    logic [7:0] target = 8'd0;
    logic [7:0] duty_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // Reference model state
    int m_duty = 0;
    int m_tgt  = 0;
    int m_intv = 0;
    int m_cnt  = 0;

    int norm_tbl[8]    = '{147, 74, 49, 29, 18, 12, 6, 3};
    int stretch_tbl[8] = '{205, 102, 68, 41, 25, 17, 9, 4};

    always #2 clk = ~clk;

    fan_duty_ramp i_fan_duty_ramp (
        .clk           (clk),
        .rst           (rst),
        .tick_1ms_i    (tick),
        .chan_sel_i    (chan_sel),
        .rate_local_i  (rate_local),
        .rate_rem1_i   (rate_rem1),
        .rate_rem2_i   (rate_rem2),
        .slow_local_i  (slow_local),
        .slow_rem1_i   (slow_rem1),
        .slow_rem2_i   (slow_rem2),
        .extra_slow_i  (extra_slow),
        .below_limit_i (below),
        .hold_min_i    (hold_min),
        .min_duty_i    (min_duty),
        .target_duty_i (target),
        .duty_o        (duty_o)
    );

    function automatic int model_goal();
        if (!below) return int'(target);
        return hold_min ? int'(min_duty) : 0;
    endfunction

    function automatic int model_intv();
        int code;
        bit slow;
        int base;
        case (chan_sel)
            2'd1:    begin code = int'(rate_rem1);  slow = slow_rem1;  end
            2'd2:    begin code = int'(rate_rem2);  slow = slow_rem2;  end
            default: begin code = int'(rate_local); slow = slow_local; end
        endcase
        base = extra_slow ? stretch_tbl[code] : norm_tbl[code];
        return slow ? base * 4 : base;
    endfunction

    task automatic expect_duty(input int value, input string req);
        exp_t e;
        e.duty = 8'(value);
        e.req  = req;
        sb_q.push_back(e);
    endtask

    // Called at a falling edge after inputs change; ticks stay low
    task automatic settle(input string req);
        int ng;
        int ni;
        repeat (3) @(negedge clk);
        ng = model_goal();
        ni = model_intv();
        if (ng != m_tgt || ni != m_intv) m_cnt = 0;
        m_tgt  = ng;
        m_intv = ni;
        expect_duty(m_duty, req);
    endtask

    task automatic tick_once(input string req);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (m_duty != m_tgt) begin
            m_cnt++;
            if (m_cnt >= m_intv) begin
                m_cnt = 0;
                m_duty = (m_tgt > m_duty) ? m_duty + 1 : m_duty - 1;
            end
        end else begin
            m_cnt = 0;
        end
        expect_duty(m_duty, req);
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n, input string req);
        for (int i = 0; i < n; i++) tick_once(req);
    endtask

    // Monitor: compare queued expectations after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (duty_o !== e.duty) begin
                    errors++;
                    $display("FAIL %s: duty_o=%0d expected %0d", e.req, duty_o, e.duty);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run still busy, actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates ticks and a nonzero request
        rate_local = 3'd7;
        target     = 8'd10;
        repeat (2) @(negedge clk);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        expect_duty(0, "R1 reset holds zero");
        @(negedge clk);
        rst = 1'b0;
        settle("R1 after release");

        // R6: ramp up at 3 ticks per step, then hold at the goal
        run_ticks(40, "R6 ramp up and hold");

        // R6: ramp down without passing the goal
        target = 8'd4;
        settle("R7 goal change keeps duty");
        run_ticks(22, "R6 ramp down");

        // R2: each normal-table interval
        for (int c = 0; c < 8; c++) begin
            rate_local = 3'(c);
            target = 8'(m_duty + 1);
            settle("R2 rate change");
            run_ticks(norm_tbl[c] + 1, "R2 normal interval");
        end

        // R3: each stretched-table interval
        extra_slow = 1'b1;
        for (int c = 0; c < 8; c++) begin
            rate_local = 3'(c);
            target = 8'(m_duty + 1);
            settle("R3 rate change");
            run_ticks(stretch_tbl[c] + 1, "R3 stretched interval");
        end
        extra_slow = 1'b0;

        // R4: times-four slowdown on the selected context
        rate_local = 3'd7;
        slow_local = 1'b1;
        target = 8'(m_duty + 3);
        settle("R4 slow on");
        run_ticks(38, "R4 slowed interval");

        // R4: slow flag of an unselected context has no effect
        slow_local = 1'b0;
        slow_rem1  = 1'b1;
        target = 8'(m_duty + 3);
        settle("R4 other slow");
        run_ticks(10, "R4 unselected slow ignored");
        slow_rem1 = 1'b0;

        // R5: context selection
        rate_rem1 = 3'd5;
        rate_rem2 = 3'd6;
        chan_sel  = 2'd1;
        target = 8'(m_duty + 2);
        settle("R5 select remote 1");
        run_ticks(26, "R5 remote 1 rate");
        chan_sel = 2'd2;
        target = 8'(m_duty + 2);
        settle("R5 select remote 2");
        run_ticks(14, "R5 remote 2 rate");
        chan_sel = 2'd3;
        target = 8'(m_duty + 2);
        settle("R5 select code 3");
        run_ticks(8, "R5 code 3 uses local");

        // R7: restart of the count on goal change and on rate change
        chan_sel   = 2'd0;
        rate_local = 3'd4;
        target = 8'(m_duty + 5);
        settle("R7 setup");
        run_ticks(10, "R7 partial interval");
        target = 8'(m_duty + 6);
        settle("R7 goal restart keeps duty");
        run_ticks(20, "R7 full interval after goal restart");
        run_ticks(10, "R7 partial interval");
        rate_local = 3'd3;
        settle("R7 rate restart keeps duty");
        run_ticks(32, "R7 full interval after rate restart");

        // R8: below threshold with the off policy ramps to zero
        rate_local = 3'd7;
        target = 8'd60;
        settle("R6 setup");
        run_ticks(3 * (60 - m_duty) + 2, "R6 ramp to 60");
        below = 1'b1;
        hold_min = 1'b0;
        settle("R8 enter below keeps duty");
        run_ticks(3, "R8 rate limited descent");
        run_ticks(3 * m_duty + 4, "R8 reach zero");

        // R9: below threshold with the hold policy goes to the minimum
        min_duty = 8'd30;
        hold_min = 1'b1;
        settle("R9 hold policy");
        run_ticks(94, "R9 ramp to minimum");
        below = 1'b0;
        target = 8'd45;
        settle("R9 leave below keeps duty");
        run_ticks(48, "R9 rate limited exit");

        // R6: full-scale top end, then full sweep down to zero
        target = 8'd255;
        settle("R6 to full scale");
        run_ticks(3 * (255 - m_duty) + 3, "R6 saturate at 255");
        target = 8'd0;
        settle("R6 to zero");
        run_ticks(768, "R6 full sweep down");

        // R3 and R4 combined: longest interval
        rate_local = 3'd0;
        extra_slow = 1'b1;
        slow_local = 1'b1;
        target = 8'd1;
        settle("R4 longest setup");
        run_ticks(822, "R4 stretched and slowed interval");

        // R10: no change without ticks
        target = 8'd200;
        settle("R10 setup");
        repeat (50) @(negedge clk);
        expect_duty(m_duty, "R10 idle without ticks");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule